// File: doc/BRIEF.md
# Dual-Clock 9-Bit FIFO with Programmable Threshold Flags

This block buffers 9-bit words between a write clock domain and an unrelated read clock domain. Each side keeps a binary and a Gray-coded pointer. The Gray pointer crosses to the other side through a two-flop synchronizer. Each side derives its own status flags from its own pointer and the synchronized copy of the opposite pointer. The write side reports full and almost-full. The read side reports empty and almost-empty. The two threshold flags compare the fill level against two offset registers. After reset, both offsets hold 7.

The data ports are not valid/ready. Back-pressure is carried by the flags. A write attempted while `full` is high is dropped. A read attempted while `empty` is high leaves the output register unchanged. The pin `wr_en_b` has two uses, and the block latches which one applies on each write-clock edge while reset is held low:
- If the pin was high, it becomes a second write enable.
- If the pin was low, it becomes a load strobe that routes `wr_data` into the offset registers.

Reading takes both read enables. The output word is registered. It is presented as data plus a drive indication that mirrors the active-low output enable, so a tri-state pad can be built outside the block. Reset is synchronous in both domains and must be held for at least four cycles of the slower clock. Both clocks may keep running during reset. The offsets are meant to be loaded while the FIFO is idle, because the read side uses the almost-empty offset without resynchronizing it.

Top module: `dcff_top`

## Requirements
- R1: While `rst_n` is low and for the first cycles afterwards: `empty` and `almost_empty` are 1, `full` and `almost_full` are 0, `rd_data` is 0, both offsets are 7, and the offset load slot points to the almost-empty offset.
- R2: If `wr_en_b` was 1 during reset, a word is stored only on a write-clock edge where both `wr_en_a` and `wr_en_b` are 1. A write with only `wr_en_a` high stores nothing.
- R3: If `wr_en_b` was 0 during reset, a write edge with `wr_en_a`=1 and `wr_en_b`=0 stores a word. An edge with both at 1 stores nothing in the FIFO; instead it writes the current offset slot.
  - Slot order: almost-empty offset first, then almost-full offset, wrapping back to the start.
  - For depths of 1024 and above, each offset takes two slots, low 9 bits first.
- R4: A read happens only when `rd_en_a` and `rd_en_b` are both 1. Words come out in write order. `rd_data` takes the word on the read-clock edge of an accepted read and holds otherwise.
- R5: `rd_drive` is 1 exactly when `out_en_n` is 0. `out_en_n` does not alter `rd_data` or the FIFO contents.
- R6: Writes while `full` is 1 are dropped, and stored words are never overwritten.
- R7: Reads while `empty` is 1 are dropped, and `rd_data` holds its last value.
- R8: `full` rises right after the write edge that brings the level to DEPTH. `empty` rises right after the read edge that brings the level to 0.
- R9: With the other side settled, `almost_full` = (level >= DEPTH - almost-full offset) and `almost_empty` = (level <= almost-empty offset).
- R10: Pointers cross domains in Gray code, changing at most one bit per edge. A write reaches the read side's `empty` within three read-clock edges. The latched mode never changes outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset, sampled by both clocks |
| wr_en_a | input | 1 | Primary write enable, active high |
| wr_en_b | input | 1 | Mode pin during reset; second write enable or offset load strobe afterwards |
| wr_data | input | 9 | Write word or offset piece |
| rd_en_a | input | 1 | First read enable, active high |
| rd_en_b | input | 1 | Second read enable, active high |
| out_en_n | input | 1 | Active-low output enable |
| rd_data | output | 9 | Registered read word |
| rd_drive | output | 1 | High when `rd_data` should drive the pins |
| empty | output | 1 | No word readable (read clock) |
| almost_empty | output | 1 | Level at or below the almost-empty offset (read clock) |
| full | output | 1 | No room left (write clock) |
| almost_full | output | 1 | Level at or above DEPTH minus the almost-full offset (write clock) |

## Verification
The embedded properties check the following on every cycle:
- A blocked write or read moves no pointer.
- Gray pointers step by at most one bit.
- Full implies almost-full, and empty implies almost-empty.
- The write-side level never exceeds DEPTH.
- The output register holds when no read is accepted.
- The latched mode is frozen outside reset.

Only the bench scenarios can show the following:
- Data comes out in the right order.
- The mode chosen at reset decides which enable combinations store data or load offsets.
- Offset slots are taken in order and wrap, and the slot pointer returns to the first slot on reset.
- The threshold flags switch at the exact level set by loaded and default offsets.

// File: rtl/dcff_pkg.sv
package dcff_pkg;
  localparam int DW          = 9;
  localparam int OFF_DEFAULT = 7;
  localparam int GW          = 16;

  typedef logic [DW-1:0] word_t;

  function automatic logic [GW-1:0] bin_to_gray(input logic [GW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [GW-1:0] gray_to_bin(input logic [GW-1:0] g);
    logic [GW-1:0] b;
    b[GW-1] = g[GW-1];
    for (int i = GW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/dcff_sync.sv
module dcff_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/dcff_wr.sv
module dcff_wr
  import dcff_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_a,
  input  logic          wr_en_b,
  input  word_t         wr_data,
  input  logic [PW-1:0] rgray_s,
  output logic          mem_we,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray,
  output logic          full,
  output logic          almost_full,
  output logic [AW-1:0] pae_off,
  output logic [AW-1:0] paf_off
);
  localparam int PIECES = (AW + DW - 1) / DW;
  localparam int SLOTS  = 2 * PIECES;
  localparam int SW     = $clog2(SLOTS);

  logic          mode_q;            // 1: second write enable, 0: load strobe
  logic [SW-1:0] slot_q;
  logic [AW-1:0] off_q [2];
  logic [PW-1:0] wbin_q, wgray_q, rbin_s, level;
  logic [AW-1:0] pmask;
  logic          ld_hit, data_try, push;
  int            tgt;

  assign ld_hit   = wr_en_a && !mode_q && wr_en_b;
  assign data_try = wr_en_a && (mode_q ? wr_en_b : !wr_en_b);
  assign rbin_s   = PW'(gray_to_bin(GW'(rgray_s)));
  assign level    = wbin_q - rbin_s;
  assign full     = (level == PW'(DEPTH));
  assign almost_full = (level >= (PW'(DEPTH) - {1'b0, off_q[1]}));
  assign push     = data_try && !full;

  // Select which register and which 9-bit piece the current slot writes.
  always_comb begin
    pmask = '0;
    tgt   = int'(slot_q) / PIECES;
    for (int p = 0; p < PIECES; p++)
      if (int'(slot_q) % PIECES == p) pmask = AW'({DW{1'b1}}) << (DW * p);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= wr_en_b;
      slot_q  <= '0;
      wbin_q  <= '0;
      wgray_q <= '0;
      off_q[0] <= AW'(OFF_DEFAULT);
      off_q[1] <= AW'(OFF_DEFAULT);
    end else begin
      if (push) begin
        wbin_q  <= wbin_q + 1'b1;
        wgray_q <= PW'(bin_to_gray(GW'(wbin_q + 1'b1)));
      end
      if (ld_hit) begin
        for (int r = 0; r < 2; r++)
          if (tgt == r)
            off_q[r] <= (off_q[r] & ~pmask) | (AW'({PIECES{wr_data}}) & pmask);
        slot_q <= (slot_q == SW'(SLOTS - 1)) ? '0 : slot_q + 1'b1;
      end
    end
  end

  assign mem_we  = push;
  assign waddr   = wbin_q[AW-1:0];
  assign wgray   = wgray_q;
  assign pae_off = off_q[0];
  assign paf_off = off_q[1];

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full && data_try) |=> $stable(wbin_q));
  a_r8_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= PW'(DEPTH));
  a_r9_full_implies_af: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> almost_full);
  a_r10_wgray_step: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);
  a_r10_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q));
endmodule

// File: rtl/dcff_rd.sv
module dcff_rd
  import dcff_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en_a,
  input  logic          rd_en_b,
  input  logic [PW-1:0] wgray_s,
  input  logic [AW-1:0] pae_off,
  output logic          pop,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic          empty,
  output logic          almost_empty
);
  logic [PW-1:0] rbin_q, rgray_q, wbin_s, level;
  logic          rd_try;

  assign rd_try = rd_en_a && rd_en_b;
  assign wbin_s = PW'(gray_to_bin(GW'(wgray_s)));
  assign level  = wbin_s - rbin_q;
  assign empty  = (rbin_q == wbin_s);
  assign almost_empty = (level <= {1'b0, pae_off});
  assign pop    = rd_try && !empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else if (pop) begin
      rbin_q  <= rbin_q + 1'b1;
      rgray_q <= PW'(bin_to_gray(GW'(rbin_q + 1'b1)));
    end
  end

  assign raddr = rbin_q[AW-1:0];
  assign rgray = rgray_q;

  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_try) |=> $stable(rbin_q));
  a_r9_empty_implies_ae: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> almost_empty);
  a_r10_rgray_step: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rgray_q ^ $past(rgray_q)) <= 1);
endmodule

// File: rtl/dcff_top.sv
module dcff_top
  import dcff_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wr_en_a,
  input  logic          wr_en_b,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en_a,
  input  logic          rd_en_b,
  input  logic          out_en_n,
  output logic [DW-1:0] rd_data,
  output logic          rd_drive,
  output logic          empty,
  output logic          almost_empty,
  output logic          full,
  output logic          almost_full
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0] waddr, raddr, pae_off, paf_off;
  logic          mem_we, pop;
  word_t         mem [DEPTH];
  word_t         dout_q;

  dcff_wr #(.DEPTH(DEPTH)) u_wr (
    .clk(wclk), .rst_n(rst_n), .wr_en_a(wr_en_a), .wr_en_b(wr_en_b),
    .wr_data(wr_data), .rgray_s(rgray_s), .mem_we(mem_we), .waddr(waddr),
    .wgray(wgray), .full(full), .almost_full(almost_full),
    .pae_off(pae_off), .paf_off(paf_off)
  );

  dcff_rd #(.DEPTH(DEPTH)) u_rd (
    .clk(rclk), .rst_n(rst_n), .rd_en_a(rd_en_a), .rd_en_b(rd_en_b),
    .wgray_s(wgray_s), .pae_off(pae_off), .pop(pop), .raddr(raddr),
    .rgray(rgray), .empty(empty), .almost_empty(almost_empty)
  );

  dcff_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s));
  dcff_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

  always_ff @(posedge wclk) begin
    if (mem_we) mem[waddr] <= wr_data;
  end

  always_ff @(posedge rclk) begin
    if (!rst_n)   dout_q <= '0;
    else if (pop) dout_q <= mem[raddr];
  end

  assign rd_data  = dout_q;
  assign rd_drive = !out_en_n;

  a_r4_dout_hold: assert property (@(posedge rclk) disable iff (!rst_n)
    !pop |=> $stable(dout_q));
  a_r5_drive_level: assert property (@(posedge rclk) disable iff (!rst_n)
    $fell(out_en_n) |-> rd_drive);
endmodule

// File: tb/tb_dcff_top.sv
module tb_dcff_top;
  localparam int WCLK_P = 10;
  localparam int RCLK_P = 14;
  localparam int DEPTH  = 64;
  localparam int AW     = $clog2(DEPTH);
  localparam int PIECES = (AW + 8) / 9;

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic wr_en_a = 0, wr_en_b = 0, rd_en_a = 0, rd_en_b = 0, out_en_n = 0;
  logic [8:0] wr_data = '0;
  logic [8:0] rd_data;
  logic rd_drive, empty, almost_empty, full, almost_full;

  int nchk = 0, nerr = 0;
  int q[$];
  int pae, paf, slot, exp_dout;
  bit dual;
  bit done = 0;

  always #(WCLK_P/2) wclk = ~wclk;
  always #(RCLK_P/2) rclk = ~rclk;

  dcff_top #(.DEPTH(DEPTH)) dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en_a(wr_en_a), .wr_en_b(wr_en_b),
    .wr_data(wr_data), .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .out_en_n(out_en_n),
    .rd_data(rd_data), .rd_drive(rd_drive), .empty(empty), .almost_empty(almost_empty),
    .full(full), .almost_full(almost_full)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge rclk);
    repeat (5) @(negedge wclk);
  endtask

  task automatic do_reset(input bit pin);
    rst_n = 0; wr_en_a = 0; rd_en_a = 0; rd_en_b = 0; wr_en_b = pin;
    repeat (4) @(negedge rclk);
    @(negedge wclk);
    rst_n = 1; wr_en_b = 0;
    dual = pin; q.delete(); pae = 7; paf = 7; slot = 0; exp_dout = 0;
    settle();
  endtask

  task automatic load_slot(input int data);
    int r, p, m, v;
    r = slot / PIECES; p = slot % PIECES;
    m = ((1 << 9) - 1) << (9 * p);
    v = ((data & 'h1FF) << (9 * p)) & m & (DEPTH - 1);
    m = m & (DEPTH - 1);
    if (r == 0) pae = (pae & ~m) | v; else paf = (paf & ~m) | v;
    slot = (slot + 1) % (2 * PIECES);
  endtask

  task automatic wr_op(input bit a, input bit b, input int data);
    @(negedge wclk);
    wr_en_a = a; wr_en_b = b; wr_data = data[8:0];
    @(negedge wclk);
    wr_en_a = 0; wr_en_b = 0;
    if (a) begin
      if (dual) begin
        if (b && q.size() < DEPTH) q.push_back(data & 'h1FF);
      end else if (b) load_slot(data);
      else if (q.size() < DEPTH) q.push_back(data & 'h1FF);
    end
    chk("R8 full", full, q.size() == DEPTH);
    chk("R9 almost_full", almost_full, q.size() >= DEPTH - paf);
  endtask

  task automatic rd_op(input bit a, input bit b);
    @(negedge rclk);
    rd_en_a = a; rd_en_b = b;
    @(negedge rclk);
    rd_en_a = 0; rd_en_b = 0;
    if (a && b && q.size() > 0) exp_dout = q.pop_front();
    chk("R4 rd_data", rd_data, exp_dout);
    chk("R8 empty", empty, q.size() == 0);
    chk("R9 almost_empty", almost_empty, q.size() <= pae);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge wclk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    // R1: reset state in second-enable mode
    do_reset(1);
    chk("R1 empty", empty, 1);
    chk("R1 almost_empty", almost_empty, 1);
    chk("R1 full", full, 0);
    chk("R1 almost_full", almost_full, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R5 drive", rd_drive, 1);

    // R2: single enable stores nothing
    wr_op(1, 0, 'h55);
    settle();
    chk("R2 no store", empty, 1);

    // Fill completely, flags compared after each write (R8, R9)
    for (int i = 0; i < DEPTH; i++) wr_op(1, 1, (i * 7 + 3) & 'h1FF);
    // R6: writes while full dropped
    wr_op(1, 1, 'h1AA);
    wr_op(1, 1, 'h0AA);
    chk("R6 still full", full, 1);
    settle();

    // R5: output enable only changes drive
    out_en_n = 1;
    #1 chk("R5 drive off", rd_drive, 0);
    chk("R5 data kept", rd_data, 0);
    out_en_n = 0;
    #1 chk("R5 drive on", rd_drive, 1);

    // R4: one read enable alone does nothing
    rd_op(1, 0);
    rd_op(0, 1);
    for (int i = 0; i < DEPTH; i++) rd_op(1, 1);
    // R7: read on empty holds data
    rd_op(1, 1);
    chk("R7 hold", rd_data, ((DEPTH - 1) * 7 + 3) & 'h1FF);

    // R10: crossing latency to empty
    wr_op(1, 1, 'h123);
    repeat (4) @(negedge rclk);
    chk("R10 empty cleared", empty, 0);
    settle();
    rd_op(1, 1);

    // R3: load mode, offsets in slot order
    do_reset(0);
    chk("R1 rd_data reset", rd_data, 0);
    wr_op(1, 1, 3);
    wr_op(1, 1, 10);
    settle();
    chk("R3 load not stored", empty, 1);
    for (int i = 0; i < 60; i++) wr_op(1, 0, 'h100 + i);
    settle();
    for (int i = 0; i < 60; i++) rd_op(1, 1);
    // R3: slot wraps to the almost-empty offset
    wr_op(1, 1, 20);
    for (int i = 0; i < 25; i++) wr_op(1, 0, i);
    settle();
    for (int i = 0; i < 25; i++) rd_op(1, 1);

    // R1: slot pointer back to first slot after reset, other offset default
    do_reset(0);
    wr_op(1, 1, 2);
    for (int i = 0; i < 60; i++) wr_op(1, 0, 'h1F0 ^ i);
    settle();
    for (int i = 0; i < 60; i++) rd_op(1, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule